// File: doc/BRIEF.md
# Half-Duplex Collision Jam and Retry Controller

This block sits in the transmit path of a half-duplex Ethernet MAC and handles collisions. It takes frame bytes from an upstream source through a valid/ready stream. For every attempt it puts eight bytes of preamble and start delimiter on a byte-wide line interface, then the frame bytes, one byte per clock. While the line is driven it watches the collision input from the PHY. When a collision is seen it stops the data and sends a fixed 32-bit jam. If the collision falls in the preamble, the delimiter is completed first and the jam follows it.

A collision on one of the first 64 bytes of an attempt (preamble and delimiter included) is an early collision. After an early collision the block waits a random truncated binary exponential backoff, then sends the frame again. The bytes that already went out are replayed from a local 64-byte buffer, so the source never has to rewind. A collision later than that is a late collision: the rest of the frame is drained from the source without being sent, and a sticky status flag is raised. An interrupt flag is also raised if it is enabled. When a frame reaches its sixteenth collision it is abandoned with an excessive-collision flag.

Top module: `hdx_jam_retry`

## Requirements
- R1: Every attempt begins with seven bytes of 0x55 and then one byte of 0xD5, with tx_en_o high and one byte per clock. Byte index 0 of the attempt is the first of these bytes.
- R2: After the delimiter the frame bytes follow in order. src_ready_o is high only in cycles where a source byte is taken. A frame with no collision ends after the byte marked by src_last_i, and done_o pulses for one cycle in the cycle after that byte.
- R3: A collision during the frame bytes (col_i high in a cycle where tx_en_o is high) makes the next four bytes the jam. The jam is the 32-bit value 0x5555_5555 sent least significant byte first. After the jam, tx_en_o goes low.
- R4: A collision during preamble or delimiter does not shorten them. The attempt is the full eight bytes followed by the four jam bytes, 12 bytes in total.
- R5: A collision on byte index 63 or lower is early. retry_o pulses for one cycle right after the last jam byte, while tx_en_o is low.
- R6: A retry resends the preamble, the delimiter and then the same frame bytes in the same order. The bytes already taken come from the local buffer, and no source byte is requested twice.
- R7: After the n-th collision of a frame, the number of cycles from the retry_o cycle to the first byte of the next attempt is r*SLOT_CYCLES+1, with 0 <= r < 2^min(n,10).
- R8: A collision on byte index 64 or higher is late. The frame is not retried. discard_o pulses, late_col_o is set, and the rest of the source frame is consumed with tx_en_o low.
- R9: late_irq_o is set by a late collision only if late_irq_en_i is high at that time.
- R10: The sixteenth collision of a frame abandons it. discard_o pulses, excess_col_o is set, retry_o does not pulse, and the rest of the frame is drained.
- R11: late_col_o, late_irq_o and excess_col_o stay set until the next frame starts, and they read 0 from its first preamble byte.
- R12: col_i has no effect while tx_en_o is low or while the jam is being sent.
- R13: The backoff draw comes from a free-running LFSR with a nonzero seed. Its state is never zero, and successive draws differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one line byte per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| src_data_i | input | 8 | Frame byte from the source |
| src_valid_i | input | 1 | Source byte valid; in idle, starts a frame |
| src_last_i | input | 1 | Source byte is the last of its frame |
| src_ready_o | output | 1 | Source byte taken this cycle |
| col_i | input | 1 | Collision indication from the PHY |
| late_irq_en_i | input | 1 | Enable for the late-collision interrupt flag |
| tx_data_o | output | 8 | Byte on the line |
| tx_en_o | output | 1 | Line byte valid |
| retry_o | output | 1 | One-cycle pulse: backoff started, retry scheduled |
| discard_o | output | 1 | One-cycle pulse: frame abandoned |
| done_o | output | 1 | One-cycle pulse: frame sent without collision |
| late_col_o | output | 1 | Sticky late-collision status |
| late_irq_o | output | 1 | Sticky late-collision interrupt flag |
| excess_col_o | output | 1 | Sticky excessive-collision status |

## Verification
The assertions cover the properties that hold on every cycle:
- each attempt opens with a preamble byte;
- the cycle after a data-phase collision carries the first jam byte;
- retry and discard pulses occur only while the line is quiet, and never together;
- the interrupt flag never rises without the late status;
- the LFSR is never zero, the retransmit buffer is never written past its depth, and an expired backoff timer stays expired until reloaded.

Only the bench scenarios can show:
- the byte-exact fragment lengths;
- the boundary between byte index 63 and 64;
- the replayed data of a retry matching the first attempt with no repeated source request;
- the backoff gap bounds growing with the collision count;
- the sixteen-collision abandon with a full drain of the source.

// File: rtl/hdx_jam_pkg.sv
`timescale 1ns/1ps
package hdx_jam_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PRE     = 3'd1,
        ST_DATA    = 3'd2,
        ST_JAM     = 3'd3,
        ST_BACKOFF = 3'd4,
        ST_DRAIN   = 3'd5
    } tx_state_e;

    localparam logic [7:0] PRE_BYTE = 8'h55;
    localparam logic [7:0] SFD_BYTE = 8'hD5;
endpackage

// File: rtl/hdx_backoff_lfsr.sv
`timescale 1ns/1ps
module hdx_backoff_lfsr #(
    parameter int          LFSR_W = 16,
    parameter int          OUT_W  = 10,
    parameter logic [15:0] TAPS   = 16'hB400,
    parameter logic [15:0] SEED   = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rand_o
);
    logic [LFSR_W-1:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = lfsr_q >> 1;
        if (lfsr_q[0]) begin
            lfsr_d = lfsr_d ^ TAPS[LFSR_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= SEED[LFSR_W-1:0];
        else        lfsr_q <= lfsr_d;
    end

    assign rand_o = lfsr_q[OUT_W-1:0];

    // R13: the generator never falls into the all-zero lock state
    p_lfsr_nonzero_r13: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);
endmodule

// File: rtl/hdx_backoff_timer.sv
`timescale 1ns/1ps
module hdx_backoff_timer #(
    parameter int SLOT_CYCLES = 64,
    parameter int SLOTS_W     = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [SLOTS_W-1:0] slots_i,
    output logic               expired_o
);
    localparam int CYC_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(SLOT_CYCLES - 1);

    logic [SLOTS_W-1:0] slots_d, slots_q;
    logic [CYC_W-1:0]   cyc_d, cyc_q;

    always_comb begin
        slots_d = slots_q;
        cyc_d   = cyc_q;
        if (load_i) begin
            slots_d = slots_i;
            cyc_d   = '0;
        end else if (slots_q != '0) begin
            if (cyc_q == CYC_LAST) begin
                cyc_d   = '0;
                slots_d = slots_q - 1'b1;
            end else begin
                cyc_d = cyc_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots_q <= '0;
            cyc_q   <= '0;
        end else begin
            slots_q <= slots_d;
            cyc_q   <= cyc_d;
        end
    end

    assign expired_o = (slots_q == '0);

    // R7: once the wait is over it stays over until a new draw is loaded
    p_expired_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !load_i) |=> expired_o);
endmodule

// File: rtl/hdx_retx_buffer.sv
`timescale 1ns/1ps
module hdx_retx_buffer #(
    parameter int DEPTH = 64,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en_i,
    input  logic [$clog2(DEPTH+1)-1:0] wr_fill_i,
    input  logic [W-1:0]               wr_data_i,
    input  logic [$clog2(DEPTH)-1:0]   rd_addr_i,
    output logic [W-1:0]               rd_data_o
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem_q[wr_fill_i[AW-1:0]] <= wr_data_i;
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];

    // R6: the replay store is never written beyond its depth
    p_buf_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> (32'(wr_fill_i) < DEPTH));
endmodule

// File: rtl/hdx_jam_retry.sv
`timescale 1ns/1ps
module hdx_jam_retry
    import hdx_jam_pkg::*;
#(
    parameter int          BUF_DEPTH    = 64,
    parameter int          MIN_BYTES    = 64,
    parameter int          PRE_LEN      = 8,
    parameter int          MAX_ATTEMPTS = 16,
    parameter int          BO_LIMIT     = 10,
    parameter int          SLOT_CYCLES  = 64,
    parameter logic [31:0] JAM_WORD     = 32'h5555_5555,
    parameter logic [15:0] LFSR_SEED    = 16'hACE1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] src_data_i,
    input  logic       src_valid_i,
    input  logic       src_last_i,
    output logic       src_ready_o,
    input  logic       col_i,
    input  logic       late_irq_en_i,
    output logic [7:0] tx_data_o,
    output logic       tx_en_o,
    output logic       retry_o,
    output logic       discard_o,
    output logic       done_o,
    output logic       late_col_o,
    output logic       late_irq_o,
    output logic       excess_col_o
);
    localparam int JAM_LEN = 4;
    localparam int PRE_W   = $clog2(PRE_LEN);
    localparam int CNT_W   = $clog2(MIN_BYTES + 1);
    localparam int PTR_W   = $clog2(BUF_DEPTH + 1);
    localparam int AW      = $clog2(BUF_DEPTH);
    localparam int ATT_W   = $clog2(MAX_ATTEMPTS + 1);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_LEN - 1);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(MIN_BYTES);
    localparam logic [PTR_W-1:0] BUF_FULL = PTR_W'(BUF_DEPTH);

    typedef struct packed {
        tx_state_e        st;
        logic [PRE_W-1:0] pre_idx;
        logic [1:0]       jam_idx;
        logic [CNT_W-1:0] cnt;
        logic             col_pend;
        logic             late;
        logic [ATT_W-1:0] attempts;
        logic [PTR_W-1:0] rd_ptr;
        logic [PTR_W-1:0] buf_cnt;
        logic             src_done;
        logic             retry;
        logic             discard;
        logic             done;
        logic             late_sts;
        logic             late_irq;
        logic             excess;
    } ctl_t;

    ctl_t r_d, r_q;

    logic                tx_en_d;
    logic [7:0]          tx_byte_d;
    logic                src_ready_d;
    logic                buf_we_d;
    logic                tmr_load_d;
    logic                byte_last_d;
    logic                replay_d;
    logic                tmr_expired;
    logic [7:0]          buf_rd_data;
    logic [BO_LIMIT-1:0] rand_bits;
    logic [BO_LIMIT-1:0] bo_mask_d;
    logic [BO_LIMIT-1:0] bo_draw_d;
    logic [ATT_W-1:0]    att_next_d;
    logic                give_up_d;

    hdx_backoff_lfsr #(
        .LFSR_W (16),
        .OUT_W  (BO_LIMIT),
        .TAPS   (16'hB400),
        .SEED   (LFSR_SEED)
    ) u_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .rand_o (rand_bits)
    );

    hdx_backoff_timer #(
        .SLOT_CYCLES (SLOT_CYCLES),
        .SLOTS_W     (BO_LIMIT)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load_d),
        .slots_i   (bo_draw_d),
        .expired_o (tmr_expired)
    );

    hdx_retx_buffer #(
        .DEPTH (BUF_DEPTH),
        .W     (8)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (buf_we_d),
        .wr_fill_i (r_q.buf_cnt),
        .wr_data_i (src_data_i),
        .rd_addr_i (r_q.rd_ptr[AW-1:0]),
        .rd_data_o (buf_rd_data)
    );

    // Truncated exponent: mask keeps min(attempt, BO_LIMIT) low bits
    always_comb begin
        att_next_d = r_q.attempts + 1'b1;
        for (int i = 0; i < BO_LIMIT; i++) begin
            bo_mask_d[i] = (32'(att_next_d) > i);
        end
        bo_draw_d = rand_bits & bo_mask_d;
        give_up_d = (32'(att_next_d) >= MAX_ATTEMPTS);
    end

    always_comb begin
        r_d         = r_q;
        r_d.retry   = 1'b0;
        r_d.discard = 1'b0;
        r_d.done    = 1'b0;
        tx_en_d     = 1'b0;
        tx_byte_d   = '0;
        src_ready_d = 1'b0;
        buf_we_d    = 1'b0;
        tmr_load_d  = 1'b0;
        byte_last_d = 1'b0;
        replay_d    = (r_q.rd_ptr < r_q.buf_cnt);

        unique case (r_q.st)
            ST_IDLE: begin
                if (src_valid_i) begin
                    r_d.st       = ST_PRE;
                    r_d.pre_idx  = '0;
                    r_d.cnt      = '0;
                    r_d.col_pend = 1'b0;
                    r_d.late     = 1'b0;
                    r_d.attempts = '0;
                    r_d.rd_ptr   = '0;
                    r_d.buf_cnt  = '0;
                    r_d.src_done = 1'b0;
                    r_d.late_sts = 1'b0;
                    r_d.late_irq = 1'b0;
                    r_d.excess   = 1'b0;
                end
            end

            ST_PRE: begin
                tx_en_d   = 1'b1;
                tx_byte_d = (r_q.pre_idx == PRE_LAST) ? SFD_BYTE : PRE_BYTE;
                if (r_q.cnt != CNT_SAT) r_d.cnt = r_q.cnt + 1'b1;
                if (col_i) r_d.col_pend = 1'b1;
                if (r_q.pre_idx == PRE_LAST) begin
                    if (r_q.col_pend || col_i) begin
                        r_d.st      = ST_JAM;
                        r_d.jam_idx = '0;
                        r_d.late    = 1'b0;
                    end else begin
                        r_d.st = ST_DATA;
                    end
                end else begin
                    r_d.pre_idx = r_q.pre_idx + 1'b1;
                end
            end

            ST_DATA: begin
                if (replay_d) begin
                    tx_en_d     = 1'b1;
                    tx_byte_d   = buf_rd_data;
                    byte_last_d = r_q.src_done && (r_q.rd_ptr == r_q.buf_cnt - 1'b1);
                    r_d.rd_ptr  = r_q.rd_ptr + 1'b1;
                end else begin
                    src_ready_d = 1'b1;
                    tx_en_d     = src_valid_i;
                    tx_byte_d   = src_data_i;
                    byte_last_d = src_last_i;
                    if (src_valid_i) begin
                        if (r_q.buf_cnt != BUF_FULL) begin
                            buf_we_d    = 1'b1;
                            r_d.buf_cnt = r_q.buf_cnt + 1'b1;
                            r_d.rd_ptr  = r_q.rd_ptr + 1'b1;
                        end
                        if (src_last_i) r_d.src_done = 1'b1;
                    end
                end
                if (tx_en_d) begin
                    if (r_q.cnt != CNT_SAT) r_d.cnt = r_q.cnt + 1'b1;
                    if (col_i) begin
                        r_d.st      = ST_JAM;
                        r_d.jam_idx = '0;
                        r_d.late    = (r_q.cnt == CNT_SAT);
                    end else if (byte_last_d) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                    end
                end
            end

            ST_JAM: begin
                tx_en_d   = 1'b1;
                tx_byte_d = JAM_WORD[8*r_q.jam_idx +: 8];
                if (32'(r_q.jam_idx) == JAM_LEN - 1) begin
                    if (r_q.late) begin
                        r_d.late_sts = 1'b1;
                        r_d.late_irq = r_q.late_irq | late_irq_en_i;
                        r_d.discard  = 1'b1;
                        r_d.st       = r_q.src_done ? ST_IDLE : ST_DRAIN;
                    end else if (give_up_d) begin
                        r_d.attempts = att_next_d;
                        r_d.excess   = 1'b1;
                        r_d.discard  = 1'b1;
                        r_d.st       = r_q.src_done ? ST_IDLE : ST_DRAIN;
                    end else begin
                        r_d.attempts = att_next_d;
                        r_d.retry    = 1'b1;
                        tmr_load_d   = 1'b1;
                        r_d.st       = ST_BACKOFF;
                    end
                end else begin
                    r_d.jam_idx = r_q.jam_idx + 1'b1;
                end
            end

            ST_BACKOFF: begin
                if (tmr_expired) begin
                    r_d.st       = ST_PRE;
                    r_d.pre_idx  = '0;
                    r_d.cnt      = '0;
                    r_d.col_pend = 1'b0;
                    r_d.late     = 1'b0;
                    r_d.rd_ptr   = '0;
                end
            end

            ST_DRAIN: begin
                src_ready_d = 1'b1;
                if (src_valid_i && src_last_i) begin
                    r_d.st = ST_IDLE;
                end
            end

            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_en_o      = tx_en_d;
    assign tx_data_o    = tx_byte_d;
    assign src_ready_o  = src_ready_d;
    assign retry_o      = r_q.retry;
    assign discard_o    = r_q.discard;
    assign done_o       = r_q.done;
    assign late_col_o   = r_q.late_sts;
    assign late_irq_o   = r_q.late_irq;
    assign excess_col_o = r_q.excess;

    // R1: a fresh attempt on the line opens with a preamble byte
    p_attempt_opens_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_en_o) && !src_ready_o) |-> (tx_data_o == PRE_BYTE));

    // R3: a data-phase collision is followed at once by the first jam byte
    p_jam_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DATA && tx_en_o && col_i) |=> (tx_en_o && tx_data_o == JAM_WORD[7:0]));

    // R5: a retry is scheduled on a quiet line and never with a discard
    p_retry_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        retry_o |-> (!tx_en_o && !discard_o));

    // R8: an abandoned frame leaves the line quiet
    p_discard_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        discard_o |-> !tx_en_o);

    // R9: the interrupt flag only rises together with the late status
    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(late_irq_o) |-> late_col_o);

    // R10: excessive collisions abandon the frame and are not late ones
    p_excess_abandon_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(excess_col_o) |-> (discard_o && !late_col_o));
endmodule

// File: tb/hdx_jam_retry_bench.sv
`timescale 1ns/1ps
module hdx_jam_retry_bench;
    localparam int SLOT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] src_data;
    logic       src_valid, src_last, src_ready;
    logic       col = 1'b0;
    logic       irq_en = 1'b0;
    logic [7:0] tx_data;
    logic       tx_en, retry, discard, done, late_col, late_irq, excess_col;

    always #2 clk = ~clk;

    hdx_jam_retry #(.SLOT_CYCLES(SLOT)) u_hdx_jam_retry (
        .clk(clk), .rst_n(rst_n),
        .src_data_i(src_data), .src_valid_i(src_valid), .src_last_i(src_last),
        .src_ready_o(src_ready), .col_i(col), .late_irq_en_i(irq_en),
        .tx_data_o(tx_data), .tx_en_o(tx_en), .retry_o(retry), .discard_o(discard),
        .done_o(done), .late_col_o(late_col), .late_irq_o(late_irq),
        .excess_col_o(excess_col)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // ---------------- source model ----------------
    int src_len = 0, src_idx = 0, src_seed = 0;
    bit src_act = 1'b0;

    function automatic logic [7:0] pat(int s, int i);
        return 8'((i * 37 + s * 11 + 3) & 255);
    endfunction

    assign src_valid = src_act && (src_idx < src_len);
    assign src_data  = pat(src_seed, src_idx);
    assign src_last  = (src_idx == src_len - 1);

    always @(posedge clk) begin
        if (src_valid && src_ready) src_idx <= src_idx + 1;
    end

    // ---------------- line monitor and collision injector ----------------
    int cyc = 0, att = -1, line_idx = 0;
    bit prev_en = 1'b0;
    logic [7:0] lg [0:19][0:127];
    int alen [0:19];
    int col_at [0:19];
    int col_hold = 1, col_left = 0;
    bit force_col = 1'b0;
    int n_retry = 0, n_discard = 0, n_done = 0;
    int ret_cyc = 0;
    bit ret_pend = 1'b0;
    int bo_bad = 0, bo_seen = 0, gap_first = -1;
    bit gap_varied = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (retry) begin
            n_retry++;
            ret_cyc  = cyc;
            ret_pend = 1'b1;
        end
        if (discard) n_discard++;
        if (done) n_done++;
        if (tx_en && !prev_en) begin
            att++;
            line_idx = 0;
            if (ret_pend) begin
                int gap, k, bound;
                gap   = cyc - ret_cyc;
                k     = (n_retry < 10) ? n_retry : 10;
                bound = ((1 << k) - 1) * SLOT + 1;
                bo_seen++;
                if (gap < 1 || gap > bound || ((gap - 1) % SLOT) != 0) bo_bad++;
                if (gap_first < 0) gap_first = gap;
                else if (gap != gap_first) gap_varied = 1'b1;
                ret_pend = 1'b0;
            end
        end
        if (tx_en && att >= 0 && att < 20 && line_idx < 128) begin
            lg[att][line_idx] = tx_data;
            alen[att] = line_idx + 1;
        end
        if (force_col) col = 1'b1;
        else if (col_left > 0) begin
            col = 1'b1;
            col_left--;
        end else if (tx_en && att >= 0 && att < 20 && line_idx == col_at[att]) begin
            col = 1'b1;
            col_left = col_hold - 1;
        end else col = 1'b0;
        if (tx_en) line_idx++;
        prev_en = tx_en;
    end

    // ---------------- helpers ----------------
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_log();
        att = -1;
        for (int i = 0; i < 20; i++) begin
            alen[i]   = 0;
            col_at[i] = -1;
        end
        col_hold = 1;
        n_retry = 0; n_discard = 0; n_done = 0;
        bo_bad = 0; bo_seen = 0; gap_first = -1; gap_varied = 1'b0;
        ret_pend = 1'b0;
    endtask

    task automatic start_frame(int len, int seed);
        src_len  = len;
        src_seed = seed;
        src_idx  = 0;
        src_act  = 1'b1;
    endtask

    task automatic finish_frame();
        while (n_done + n_discard < 1) tick();
        while (src_idx < src_len) tick();
        repeat (8) tick();
        src_act = 1'b0;
    endtask

    // check one whole clean attempt: preamble, SFD, then all frame bytes
    task automatic chk_attempt(int a, int len, int seed, string req);
        int bad = -1;
        for (int i = 0; i < 8 + len; i++) begin
            logic [7:0] e;
            e = (i < 7) ? 8'h55 : (i == 7) ? 8'hD5 : pat(seed, i - 8);
            if (lg[a][i] !== e && bad < 0) bad = i;
        end
        chk(alen[a] == 8 + len, req, "attempt length", alen[a], 8 + len);
        chk(bad < 0, req, "first wrong byte index", bad, -1);
    endtask

    task automatic chk_jam_tail(int a, string req);
        int bad = 0;
        for (int i = alen[a] - 4; i < alen[a]; i++) begin
            if (lg[a][i] != 8'h55) bad++;
        end
        chk(bad == 0, req, "jam bytes not 0x55", bad, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(tx_en == 1'b0, "R1", "tx_en in reset state", int'(tx_en), 0);
        chk(src_ready == 1'b0, "R2", "src_ready in reset state", int'(src_ready), 0);
        chk({late_col, late_irq, excess_col} == 3'b000, "R11", "status after reset",
            int'({late_col, late_irq, excess_col}), 0);
    endtask

    task automatic t_clean();
        clear_log();
        start_frame(20, 1);
        finish_frame();
        chk_attempt(0, 20, 1, "R1");
        chk(att == 0, "R2", "attempt count", att, 0);
        chk(n_done == 1, "R2", "done pulses", n_done, 1);
        chk(src_idx == 20, "R2", "source bytes taken", src_idx, 20);
    endtask

    task automatic t_data_col();
        clear_log();
        col_at[0] = 12;
        start_frame(30, 2);
        finish_frame();
        chk(alen[0] == 17, "R3", "fragment length", alen[0], 17);
        chk(lg[0][12] == pat(2, 4), "R3", "last data byte before jam", int'(lg[0][12]), int'(pat(2, 4)));
        chk_jam_tail(0, "R3");
        chk(n_retry == 1, "R5", "retry pulses", n_retry, 1);
        chk_attempt(1, 30, 2, "R6");
        chk(src_idx == 30, "R6", "source bytes taken once", src_idx, 30);
        chk(bo_seen == 1 && bo_bad == 0, "R7", "backoff gap violations", bo_bad, 0);
        chk(n_done == 1, "R2", "done after retry", n_done, 1);
    endtask

    task automatic t_pre_col();
        clear_log();
        col_at[0] = 3;
        start_frame(25, 3);
        finish_frame();
        chk(alen[0] == 12, "R4", "preamble fragment length", alen[0], 12);
        chk(lg[0][7] == 8'hD5, "R4", "SFD completed", int'(lg[0][7]), 8'hD5);
        chk_jam_tail(0, "R4");
        chk(n_retry == 1, "R5", "retry after preamble collision", n_retry, 1);
        chk_attempt(1, 25, 3, "R6");
    endtask

    task automatic t_late_irq();
        clear_log();
        irq_en = 1'b1;
        col_at[0] = 70;
        start_frame(100, 4);
        finish_frame();
        chk(alen[0] == 75, "R8", "late fragment length", alen[0], 75);
        chk_jam_tail(0, "R8");
        chk(n_retry == 0 && att == 0, "R8", "retries after late collision", n_retry, 0);
        chk(n_discard == 1, "R8", "discard pulses", n_discard, 1);
        chk(late_col == 1'b1, "R8", "late status", int'(late_col), 1);
        chk(src_idx == 100, "R8", "source drained", src_idx, 100);
        chk(late_irq == 1'b1, "R9", "irq with enable", int'(late_irq), 1);
        chk(excess_col == 1'b0, "R10", "excess on late collision", int'(excess_col), 0);
    endtask

    task automatic t_late_noirq();
        clear_log();
        irq_en = 1'b0;
        col_at[0] = 64;
        start_frame(80, 5);
        while (!tx_en) tick();
        chk({late_col, late_irq} == 2'b00, "R11", "status at new frame start",
            int'({late_col, late_irq}), 0);
        finish_frame();
        chk(alen[0] == 69, "R8", "index 64 is late, fragment", alen[0], 69);
        chk(late_col == 1'b1 && n_retry == 0, "R8", "index 64 late status", int'(late_col), 1);
        chk(late_irq == 1'b0, "R9", "irq without enable", int'(late_irq), 0);
    endtask

    task automatic t_boundary();
        clear_log();
        col_at[0] = 63;
        col_at[1] = 64;
        start_frame(80, 6);
        finish_frame();
        chk(alen[0] == 68 && n_retry == 1, "R5", "index 63 early, retries", n_retry, 1);
        chk(alen[1] == 69, "R8", "second attempt fragment", alen[1], 69);
        chk(n_discard == 1 && late_col == 1'b1, "R8", "late on second attempt", n_discard, 1);
        chk(src_idx == 80, "R6", "source bytes after replay and drain", src_idx, 80);
    endtask

    task automatic t_excess();
        clear_log();
        for (int i = 0; i < 16; i++) col_at[i] = 10;
        start_frame(30, 7);
        finish_frame();
        chk(att == 15, "R10", "attempts made", att + 1, 16);
        chk(n_retry == 15, "R10", "retry pulses", n_retry, 15);
        chk(n_discard == 1 && excess_col == 1'b1, "R10", "excess status", int'(excess_col), 1);
        chk(late_col == 1'b0 && n_done == 0, "R10", "late status or done", int'(late_col), 0);
        chk(alen[15] == 15, "R6", "replayed attempt length", alen[15], 15);
        chk(src_idx == 30, "R10", "source drained", src_idx, 30);
        chk(bo_seen == 15 && bo_bad == 0, "R7", "backoff gap violations", bo_bad, 0);
        chk(gap_varied == 1'b1, "R13", "backoff draws vary", int'(gap_varied), 1);
    endtask

    task automatic t_ignore();
        clear_log();
        force_col = 1'b1;
        repeat (20) tick();
        force_col = 1'b0;
        repeat (2) tick();
        chk(att == -1 && n_retry == 0, "R12", "activity from idle collision", att, -1);
        chk(excess_col == 1'b1, "R12", "status kept through idle collision", int'(excess_col), 1);
        col_at[0] = 12;
        col_hold  = 5;
        start_frame(30, 8);
        finish_frame();
        chk(alen[0] == 17 && n_retry == 1, "R12", "collision during jam ignored", alen[0], 17);
        chk(att == 1 && n_done == 1, "R12", "attempts with held collision", att + 1, 2);
    endtask

    task automatic t_last_byte();
        clear_log();
        col_at[0] = 17;
        start_frame(10, 9);
        finish_frame();
        chk(alen[0] == 22 && n_retry == 1, "R5", "collision on last byte", alen[0], 22);
        chk_attempt(1, 10, 9, "R6");
        chk(src_idx == 10 && n_done == 1, "R6", "whole frame replayed from buffer", src_idx, 10);
    endtask

    // ---------------- sequencing ----------------
    initial begin
        for (int i = 0; i < 20; i++) col_at[i] = -1;
        repeat (4) tick();
        t_reset();
        rst_n = 1'b1;
        repeat (3) tick();
        t_clean();
        t_data_col();
        t_pre_col();
        t_late_irq();
        t_late_noirq();
        t_boundary();
        t_excess();
        t_ignore();
        t_last_byte();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule